// File: doc/BRIEF.md
# Half-Bridge Complementary PWM Generator

This block drives the high-side and low-side switches of a half-bridge. It runs its own period timer, which advances once per instruction-cycle tick. A duty comparator builds a nominal primary waveform from that timer. The nominal secondary waveform is the inverse of the primary.

Each of the two outputs then passes through its own dead-band delay unit. The delay unit holds back only the turn-on edge, by a programmable number of ticks, so both switches are off during every transition gap. Turn-off is never delayed.

Software-facing duty and dead-band values are held in staging inputs. They are copied into the working copies only when the timer wraps, or at any time while the block is disabled. The period value is compared directly on every tick.

Top module: `hbpwm_gen`

## Requirements
- R1: The timer advances by one on each clock with `tick` high. On the tick where it equals `period_in`, it returns to 0 on that tick instead of advancing, so one PWM cycle lasts `period_in`+1 ticks.
- R2: The nominal primary waveform is high while the timer is below the working duty value. A duty of 0 keeps the primary off for the whole cycle. A duty above `period_in` keeps the nominal primary high for the whole cycle.
- R3: The nominal secondary waveform is the exact inverse of the nominal primary while the block is enabled.
- R4: After a rising edge of either nominal waveform, the matching output turns on only once that waveform has stayed high for the working dead-band count of ticks. The output turns off on the same clock edge on which its nominal waveform falls.
- R5: When the working dead-band count is greater than or equal to the number of ticks an output's nominal waveform is high, that output stays low for the whole cycle.
- R6: With a working dead-band count of 0, `out_pri` and `out_cmp` are exact complements while enabled.
- R7: New `duty_in` and `dead_in` values are copied into the working values only on the wrap tick, or on every clock while `en` is low. Changes at any other time do not alter the waveform of the current cycle.
- R8: While `en` is low, both outputs are low and the timer and delay counters are held at 0. On the first clock with `en` high, the cycle starts from timer value 0.
- R9: `out_pri` and `out_cmp` are never high at the same time.
- R10: On clocks with `tick` low, the timer, the delay counters and the outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Module enable; low forces outputs off and clears counters |
| tick | input | 1 | Instruction-cycle enable; one timer step per high clock |
| period_in | input | TMR_W | Timer value at which the cycle wraps |
| duty_in | input | TMR_W | Staged duty value (ticks of primary nominal on-time) |
| dead_in | input | DB_W | Staged dead-band count in ticks |
| out_pri | output | 1 | Primary drive, active-high |
| out_cmp | output | 1 | Complementary drive, active-high |

## Verification
The bench builds the block with a 6-bit timer and the 7-bit dead-band count. A dead-band count can then far exceed any possible on-time, which covers both the suppressed-output case and counter saturation. The short timer also keeps a cycle of a few ticks cheap, so many cycles fit in each run.

Each of these cases is compared clock by clock against a behavioural model:
- sparse ticks at one tick in three clocks;
- duty values of 0 and above the period;
- mid-cycle changes of the staged values;
- disable and re-enable.

// File: rtl/hbpwm_pkg.sv
package hbpwm_pkg;
    // Default widths shared by the generator and its sub-units
    localparam int HB_TMR_W_DEF = 8;
    localparam int HB_DB_W_DEF  = 7;

    // Drive channel index used by the delay-unit generate loop
    typedef enum logic [0:0] {
        HB_CH_PRI = 1'b0,
        HB_CH_CMP = 1'b1
    } hb_chan_e;
endpackage

// File: rtl/hbpwm_timebase.sv
module hbpwm_timebase #(
    parameter int TMR_W = hbpwm_pkg::HB_TMR_W_DEF,
    parameter int DB_W  = hbpwm_pkg::HB_DB_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [TMR_W-1:0] period_in,
    input  logic [TMR_W-1:0] duty_in,
    input  logic [DB_W-1:0]  dead_in,
    output logic [TMR_W-1:0] timer_o,
    output logic [TMR_W-1:0] duty_o,
    output logic [DB_W-1:0]  dead_o
);
    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic [TMR_W-1:0] duty;
        logic [DB_W-1:0]  dead;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      wrap_d;

    assign wrap_d = en && tick && (st_q.tmr == period_in);

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.tmr  = '0;
            st_d.duty = duty_in;
            st_d.dead = dead_in;
        end else if (tick) begin
            if (wrap_d) begin
                st_d.tmr  = '0;
                st_d.duty = duty_in;
                st_d.dead = dead_in;
            end else begin
                st_d.tmr = st_q.tmr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign timer_o = st_q.tmr;
    assign duty_o  = st_q.duty;
    assign dead_o  = st_q.dead;

    // R1: a matching tick brings the timer back to zero
    p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_d |=> (st_q.tmr == '0));

    // R7: working copies only move on wrap or while disabled
    p_dbuf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && !$past(wrap_d)) |-> ($stable(st_q.duty) && $stable(st_q.dead)));
endmodule

// File: rtl/hbpwm_deadband.sv
module hbpwm_deadband #(
    parameter int DB_W = hbpwm_pkg::HB_DB_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            tick,
    input  logic            nom_i,
    input  logic [DB_W-1:0] dead_i,
    output logic            drv_o
);
    localparam logic [DB_W-1:0] CNT_MAX = {DB_W{1'b1}};

    typedef struct packed {
        logic [DB_W-1:0] cnt;
    } db_state_t;

    db_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (!nom_i)                st_d.cnt = '0;
            else if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // turn-off follows the nominal wave at once; turn-on waits for the count
    assign drv_o = en && nom_i && (st_q.cnt >= dead_i);

    // R4: with a nonzero delay, the drive can only rise after the nominal wave was already high
    p_late_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $rose(drv_o) && (dead_i != '0)) |-> $past(nom_i));
endmodule

// File: rtl/hbpwm_gen.sv
module hbpwm_gen #(
    parameter int TMR_W = hbpwm_pkg::HB_TMR_W_DEF,
    parameter int DB_W  = hbpwm_pkg::HB_DB_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [TMR_W-1:0] period_in,
    input  logic [TMR_W-1:0] duty_in,
    input  logic [DB_W-1:0]  dead_in,
    output logic             out_pri,
    output logic             out_cmp
);
    import hbpwm_pkg::*;

    localparam int NCH = 2;

    logic [TMR_W-1:0] tmr_w;
    logic [TMR_W-1:0] duty_w;
    logic [DB_W-1:0]  dead_w;
    logic             pri_nom;
    logic [NCH-1:0]   nom_w;
    logic [NCH-1:0]   drv_w;

    hbpwm_timebase #(.TMR_W(TMR_W), .DB_W(DB_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .tick      (tick),
        .period_in (period_in),
        .duty_in   (duty_in),
        .dead_in   (dead_in),
        .timer_o   (tmr_w),
        .duty_o    (duty_w),
        .dead_o    (dead_w)
    );

    assign pri_nom = (tmr_w < duty_w);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        if (ch == int'(HB_CH_PRI)) begin : g_pri
            assign nom_w[ch] = pri_nom;
        end else begin : g_cmp
            assign nom_w[ch] = !pri_nom;
        end
        hbpwm_deadband #(.DB_W(DB_W)) u_db (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en),
            .tick   (tick),
            .nom_i  (nom_w[ch]),
            .dead_i (dead_w),
            .drv_o  (drv_w[ch])
        );
    end

    assign out_pri = drv_w[HB_CH_PRI];
    assign out_cmp = drv_w[HB_CH_CMP];

    // R9: the two switches are never commanded on together
    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_pri && out_cmp));

    // R8: a disabled block drives nothing
    p_idle_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!out_pri && !out_cmp));

    // R6: zero delay gives exact complements
    p_zero_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (dead_w == '0)) |-> (out_pri != out_cmp));
endmodule

// File: tb/hbpwm_gen_test.sv
module hbpwm_gen_test;
    localparam int TW = 6;
    localparam int DW = 7;
    localparam int TMOD = 1 << TW;
    localparam int CMAX = (1 << DW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic tick = 1'b0;
    logic [TW-1:0] period_in = '0;
    logic [TW-1:0] duty_in = '0;
    logic [DW-1:0] dead_in = '0;
    logic out_pri, out_cmp;

    always #10 clk = ~clk;

    hbpwm_gen #(.TMR_W(TW), .DB_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
        .period_in(period_in), .duty_in(duty_in), .dead_in(dead_in),
        .out_pri(out_pri), .out_cmp(out_cmp)
    );

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R8";

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference
    int m_t = 0, m_d = 0, m_db = 0, m_cp = 0, m_cc = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_t = 0; m_d = 0; m_db = 0; m_cp = 0; m_cc = 0;
        end else if (!en) begin
            m_t = 0; m_cp = 0; m_cc = 0;
            m_d = int'(duty_in); m_db = int'(dead_in);
        end else if (tick) begin
            if (m_t < m_d) begin
                m_cp = (m_cp < CMAX) ? m_cp + 1 : CMAX; m_cc = 0;
            end else begin
                m_cc = (m_cc < CMAX) ? m_cc + 1 : CMAX; m_cp = 0;
            end
            if (m_t == int'(period_in)) begin
                m_t = 0; m_d = int'(duty_in); m_db = int'(dead_in);
            end else begin
                m_t = (m_t + 1) % TMOD;
            end
        end
    end

    always @(negedge clk) begin
        bit ep, ec;
        ep = en && (m_t < m_d) && (m_cp >= m_db);
        ec = en && !(m_t < m_d) && (m_cc >= m_db);
        check(out_pri == ep, {cur_req, " primary"}, out_pri, ep);
        check(out_cmp == ec, {cur_req, " complement"}, out_cmp, ec);
        check(!(out_pri && out_cmp), "R9", out_pri + out_cmp, 1);
    end

    // staged stimulus, applied just after a rising edge
    int tick_div = 1, cyc = 0;
    logic nx_en = 1'b0;
    logic [TW-1:0] nx_per = '0, nx_duty = '0;
    logic [DW-1:0] nx_dead = '0;
    int hi_p = 0, hi_c = 0, last_rise = -1, rise_gap = 0, run_len = 0, hi_len = 0;
    logic prev_p = 1'b0;

    task automatic run(input int n);
        repeat (n) begin
            @(posedge clk); #2;
            en = nx_en; period_in = nx_per; duty_in = nx_duty; dead_in = nx_dead;
            tick = ((cyc % tick_div) == 0);
            cyc++;
            @(negedge clk);
            hi_p += out_pri; hi_c += out_cmp;
            if (out_pri && !prev_p) begin
                if (last_rise >= 0) rise_gap = cyc - last_rise;
                last_rise = cyc;
                run_len = 0;
            end
            if (out_pri) run_len++;
            if (!out_pri && prev_p) hi_len = run_len;
            prev_p = out_pri;
        end
    endtask

    task automatic clr();
        hi_p = 0; hi_c = 0;
    endtask

    initial begin
        #(20 * 100000);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        check(out_pri == 1'b0 && out_cmp == 1'b0, "R8 reset", out_pri + out_cmp, 0);
        @(posedge clk); #2; rst_n = 1'b1;

        // R1 R2 R3 R6: plain complements
        cur_req = "R6";
        nx_per = 6'd9; nx_duty = 6'd4; nx_dead = '0; nx_en = 1'b1;
        run(45);
        check(rise_gap == 10, "R1 period", rise_gap, 10);
        check(hi_len == 4, "R2 high length", hi_len, 4);

        // R4: delayed turn-on, two ticks
        cur_req = "R4";
        nx_dead = 7'd2;
        run(15); clr(); run(40);
        check(hi_len == 2, "R4 primary on-time", hi_len, 2);
        check(hi_c == 16, "R4 complement on-time", hi_c, 16);

        // R10: one tick every three clocks
        cur_req = "R10";
        tick_div = 3;
        run(95);
        check(rise_gap == 30, "R10 sparse period", rise_gap, 30);
        tick_div = 1;

        // R2: duty zero and duty above period
        cur_req = "R2";
        nx_dead = '0; nx_duty = '0;
        run(30); clr(); run(30);
        check(hi_p == 0, "R2 duty zero primary", hi_p, 0);
        check(hi_c == 30, "R2 duty zero complement", hi_c, 30);
        nx_duty = 6'd63;
        run(30); clr(); run(30);
        check(hi_p == 30, "R2 duty over period", hi_p, 30);

        // R5: delay longer than primary on-time
        cur_req = "R5";
        nx_duty = 6'd3; nx_dead = 7'd5;
        run(30); clr(); run(40);
        check(hi_p == 0, "R5 suppressed primary", hi_p, 0);
        check(hi_c == 8, "R5 complement", hi_c, 8);
        nx_dead = 7'd100;
        run(30); clr(); run(40);
        check(hi_p + hi_c == 0, "R5 both suppressed", hi_p + hi_c, 0);

        // R7: staged values change mid-cycle; reference covers timing
        cur_req = "R7";
        nx_dead = 7'd1; nx_duty = 6'd6;
        run(23);
        nx_duty = 6'd2; nx_dead = 7'd0;
        run(4);
        nx_duty = 6'd7;
        run(30);
        check(hi_len == 7, "R7 loaded duty", hi_len, 7);

        // R8: disable, then re-enable
        cur_req = "R8";
        nx_duty = 6'd4; nx_en = 1'b0;
        run(2); clr(); run(6);
        check(hi_p + hi_c == 0, "R8 disabled outputs", hi_p + hi_c, 0);
        nx_en = 1'b1;
        run(1);
        check(out_pri == 1'b1, "R8 restart at zero", out_pri, 1);
        run(30);
        check(rise_gap == 10, "R8 period after restart", rise_gap, 10);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule